// File: doc/BRIEF.md
# I2C Wake-on-Address Slave Front End

This block listens on an I2C bus and recognises its own 7-bit slave address so that a sleeping system can be woken by bus traffic. Two recognisers exist side by side. One runs on the system clock, oversampling the bus lines. The other is clocked by the bus lines themselves, so it keeps working while the system clock is stopped. Two clock-source configuration bits, a buffered-mode select and the current power state decide which recogniser may answer.

When the bus-clocked recogniser matches, it sets a sticky wakeup cause that raises an interrupt if its mask is set. It then acts on whether the internal protocol core is ready:
- If the core is ready, it acknowledges the address.
- If the core is not ready, one policy bit makes it refuse the address (NACK).
- Otherwise it holds SCL low until the core reports ready, then releases SCL and pulses a handover strobe so the core can take over the transfer.

The data phase itself belongs to that core and is not part of this block.

Top module: `i2cw_front`

## Requirements
- R1: With op_ext_clk_i=1 and addr_ext_clk_i=0, or with op_ext_clk_i=1 and buffered_i=0, the configuration is invalid. In an invalid configuration the block never pulls SDA or SCL low, never sets the wakeup cause and never pulses handover.
- R2: With addr_ext_clk_i=0 and op_ext_clk_i=0, the system-clocked recogniser answers a matching address only in power states Active (pwr_state_i=0) and Sleep (1). It answers by pulling SDA low through the ninth SCL clock and pulsing handover_o once. In Deep-Sleep (2) it stays silent.
- R3: With addr_ext_clk_i=1 in a valid configuration, the bus-clocked recogniser answers in Active, Sleep and Deep-Sleep.
- R4: After a START, the first seven bits sampled on rising SCL, most significant first, are compared with slave_addr_i. The eighth (read/write) bit is ignored. On a mismatch SDA is left released and nothing else happens.
- R5: A match by the bus-clocked recogniser sets wake_cause_o. The bit stays set until a wake_clr_i pulse. Matches by the system-clocked recogniser do not set it.
- R6: irq_o is high exactly when wake_cause_o and wake_mask_i are both high.
- R7: On a bus-clocked match where core_ready_i is high at the falling SCL edge after the eighth bit, the block acknowledges the address and pulses handover_o once.
- R8: On a bus-clocked match with core_ready_i low and nack_not_ready_i=1, SDA stays released (NACK), SCL is not held and handover_o does not pulse.
- R9: On a bus-clocked match with core_ready_i low and nack_not_ready_i=0, SCL is held low from that falling edge on. Once core_ready_i is seen high at a clk_i rising edge, SCL is released right after that edge and handover_o pulses once. The block does not drive the acknowledge itself.
- R10: A repeated START in the middle of an address restarts address reception from the first bit.
- R11: While rst_ni is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_ext_clk_i | input | 1 | Address recognition on bus clock (1) or system clock (0) |
| op_ext_clk_i | input | 1 | Rest of transfer on bus clock (1) or system clock (0) |
| buffered_i | input | 1 | Buffered transfer mode selected |
| pwr_state_i | input | 2 | 0 Active, 1 Sleep, 2 Deep-Sleep |
| nack_not_ready_i | input | 1 | Not-ready policy: 1 refuse address, 0 hold SCL |
| core_ready_i | input | 1 | Internal protocol core is ready |
| slave_addr_i | input | 7 | Programmed slave address |
| wake_mask_i | input | 1 | Interrupt mask for the wakeup cause |
| wake_clr_i | input | 1 | Write-one-to-clear pulse for the wakeup cause |
| sda_pd_o | output | 1 | Pull SDA low |
| scl_pd_o | output | 1 | Pull SCL low (clock stretch) |
| wake_cause_o | output | 1 | Sticky wakeup cause |
| irq_o | output | 1 | Masked wakeup interrupt |
| handover_o | output | 1 | One-cycle strobe: core takes over the transfer |

## Verification
The two recognisers leave different traces on the bus. The bus-clocked one decides on the falling SCL edge itself. The system-clocked one decides a few clk_i cycles later. Either way, a wrong shift count or a wrong comparison appears at once as a missing or stray low SDA level in the ninth bit of the same frame.

A stretch that is never released hangs the bench until the watchdog expires. A release that comes late is caught one clk_i cycle after core_ready_i is raised.

Faults on the system-domain side appear within a few cycles after the frame ends, as a wakeup cause or handover count that differs from the expected one. This covers a toggle that is lost in synchronisation, a cause that does not stick, and a mask that is applied wrongly.

// File: rtl/i2cw_pkg.sv
`timescale 1ns/1ps
package i2cw_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_DEEP   = 2'd2,
    PWR_RSVD   = 2'd3
  } pwr_e;

  localparam int unsigned ADDR_W = 7;
endpackage

// File: rtl/i2cw_sync.sv
`timescale 1ns/1ps
module i2cw_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2cw_bus_matcher.sv
`timescale 1ns/1ps
// Address recogniser clocked by the bus lines only.
module i2cw_bus_matcher #(
  parameter int unsigned ADDR_W = i2cw_pkg::ADDR_W
) (
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              nack_pol_i,
  input  logic              core_ready_i,
  input  logic              release_i,
  output logic              sda_pd_o,
  output logic              scl_hold_o,
  output logic              match_tog_o,
  output logic              hand_tog_o
);
  localparam int unsigned LAST = ADDR_W + 1;
  localparam int unsigned CW   = $clog2(LAST + 2);

  logic              start_t, stop_t, start_ack, stop_ack, busy;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] sh;
  logic              decide, hit, hold_rst_n;

  // START / STOP: SDA edge while SCL high
  always_ff @(negedge sda_i or negedge rst_ni) begin
    if (!rst_ni)    start_t <= 1'b0;
    else if (scl_i) start_t <= ~start_t;
  end

  always_ff @(posedge sda_i or negedge rst_ni) begin
    if (!rst_ni)    stop_t <= 1'b0;
    else if (scl_i) stop_t <= ~stop_t;
  end

  always_ff @(posedge scl_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_ack <= 1'b0;
      stop_ack  <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
    end else begin
      start_ack <= start_t;
      stop_ack  <= stop_t;
      if (start_t != start_ack) begin
        busy <= 1'b1;
        cnt  <= CW'(1);
        sh   <= {sh[ADDR_W-2:0], sda_i};
      end else if (stop_t != stop_ack) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt < CW'(ADDR_W)) sh <= {sh[ADDR_W-2:0], sda_i};
        if (cnt == CW'(LAST)) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign decide = busy && (cnt == CW'(LAST));
  assign hit    = en_i && (sh == addr_i);

  always_ff @(negedge scl_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_pd_o    <= 1'b0;
      match_tog_o <= 1'b0;
      hand_tog_o  <= 1'b0;
    end else if (decide && hit) begin
      match_tog_o <= ~match_tog_o;
      if (core_ready_i) begin
        sda_pd_o   <= 1'b1;
        hand_tog_o <= ~hand_tog_o;
      end
    end else begin
      sda_pd_o <= 1'b0;
    end
  end

  // stretch flop, cleared asynchronously by the system-side release
  assign hold_rst_n = rst_ni & ~release_i;

  always_ff @(negedge scl_i or negedge hold_rst_n) begin
    if (!hold_rst_n) scl_hold_o <= 1'b0;
    else if (decide && hit && !core_ready_i && !nack_pol_i) scl_hold_o <= 1'b1;
  end
endmodule

// File: rtl/i2cw_sys_matcher.sv
`timescale 1ns/1ps
// Address recogniser on the system clock, oversampling synchronised lines.
module i2cw_sys_matcher #(
  parameter int unsigned ADDR_W = i2cw_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sda_pd_o,
  output logic              hand_o
);
  localparam int unsigned LAST = ADDR_W + 1;
  localparam int unsigned CW   = $clog2(LAST + 2);

  logic              p_scl, p_sda, busy;
  logic              rise, fall, start_ev, stop_ev;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] sh;

  assign rise     = !p_scl &&  scl_i;
  assign fall     =  p_scl && !scl_i;
  assign start_ev =  p_scl &&  scl_i &&  p_sda && !sda_i;
  assign stop_ev  =  p_scl &&  scl_i && !p_sda &&  sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_scl    <= 1'b1;
      p_sda    <= 1'b1;
      busy     <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      sda_pd_o <= 1'b0;
      hand_o   <= 1'b0;
    end else begin
      p_scl  <= scl_i;
      p_sda  <= sda_i;
      hand_o <= 1'b0;
      if (start_ev) begin
        busy     <= 1'b1;
        cnt      <= '0;
        sda_pd_o <= 1'b0;
      end else if (stop_ev) begin
        busy     <= 1'b0;
        cnt      <= '0;
        sda_pd_o <= 1'b0;
      end else if (rise && busy) begin
        if (cnt < CW'(ADDR_W)) sh <= {sh[ADDR_W-2:0], sda_i};
        if (cnt == CW'(LAST)) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (fall) begin
        if (busy && cnt == CW'(LAST) && en_i && sh == addr_i) begin
          sda_pd_o <= 1'b1;
          hand_o   <= 1'b1;
        end else begin
          sda_pd_o <= 1'b0;
        end
      end
    end
  end

  AST_INT_ACK_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> en_i); // R2
endmodule

// File: rtl/i2cw_sys_ctrl.sv
`timescale 1ns/1ps
// System-side wakeup cause, interrupt, stretch release and handover strobe.
module i2cw_sys_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_tog_i,
  input  logic hand_tog_i,
  input  logic stretch_i,
  input  logic int_hand_i,
  input  logic core_ready_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic wake_o,
  output logic irq_o,
  output logic release_o,
  output logic handover_o
);
  logic [2:0] s_in;
  logic       p_match, p_hand;
  logic       match_ev, hand_ev, s_str;

  i2cw_sync #(.W(3), .STAGES(2), .RST_VAL(3'b000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stretch_i, hand_tog_i, match_tog_i}),
    .q_o   (s_in)
  );

  assign s_str    = s_in[2];
  assign match_ev = s_in[0] ^ p_match;
  assign hand_ev  = s_in[1] ^ p_hand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_match    <= 1'b0;
      p_hand     <= 1'b0;
      wake_o     <= 1'b0;
      release_o  <= 1'b0;
      handover_o <= 1'b0;
    end else begin
      p_match <= s_in[0];
      p_hand  <= s_in[1];
      if (match_ev)   wake_o <= 1'b1;
      else if (clr_i) wake_o <= 1'b0;
      if (!s_str)            release_o <= 1'b0;
      else if (core_ready_i) release_o <= 1'b1;
      handover_o <= (s_str && core_ready_i && !release_o) || hand_ev || int_hand_i;
    end
  end

  assign irq_o = wake_o & mask_i;

  AST_WAKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !clr_i) |=> wake_o); // R5
  AST_RELEASE_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(release_o) |-> $past(core_ready_i)); // R9
  AST_HANDOVER_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handover_o |=> !handover_o); // R7
endmodule

// File: rtl/i2cw_front.sv
`timescale 1ns/1ps
module i2cw_front #(
  parameter int unsigned ADDR_W = i2cw_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_ext_clk_i,
  input  logic              op_ext_clk_i,
  input  logic              buffered_i,
  input  logic [1:0]        pwr_state_i,
  input  logic              nack_not_ready_i,
  input  logic              core_ready_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              wake_mask_i,
  input  logic              wake_clr_i,
  output logic              sda_pd_o,
  output logic              scl_pd_o,
  output logic              wake_cause_o,
  output logic              irq_o,
  output logic              handover_o
);
  import i2cw_pkg::*;

  logic       cfg_bad, ext_en, int_en, awake;
  logic [1:0] s_bus;
  logic       ext_sda_pd, ext_hold, match_tog, hand_tog, release_q;
  logic       int_sda_pd, int_hand;

  assign cfg_bad = op_ext_clk_i && (!addr_ext_clk_i || !buffered_i);
  assign awake   = (pwr_e'(pwr_state_i) == PWR_ACTIVE) || (pwr_e'(pwr_state_i) == PWR_SLEEP);
  assign ext_en  = !cfg_bad && addr_ext_clk_i;
  assign int_en  = !cfg_bad && !addr_ext_clk_i && awake;

  i2cw_bus_matcher #(.ADDR_W(ADDR_W)) u_bus (
    .rst_ni      (rst_ni),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .en_i        (ext_en),
    .addr_i      (slave_addr_i),
    .nack_pol_i  (nack_not_ready_i),
    .core_ready_i(core_ready_i),
    .release_i   (release_q),
    .sda_pd_o    (ext_sda_pd),
    .scl_hold_o  (ext_hold),
    .match_tog_o (match_tog),
    .hand_tog_o  (hand_tog)
  );

  i2cw_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_line_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (s_bus)
  );

  i2cw_sys_matcher #(.ADDR_W(ADDR_W)) u_sys (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (s_bus[1]),
    .sda_i   (s_bus[0]),
    .en_i    (int_en),
    .addr_i  (slave_addr_i),
    .sda_pd_o(int_sda_pd),
    .hand_o  (int_hand)
  );

  i2cw_sys_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .match_tog_i (match_tog),
    .hand_tog_i  (hand_tog),
    .stretch_i   (ext_hold),
    .int_hand_i  (int_hand),
    .core_ready_i(core_ready_i),
    .mask_i      (wake_mask_i),
    .clr_i       (wake_clr_i),
    .wake_o      (wake_cause_o),
    .irq_o       (irq_o),
    .release_o   (release_q),
    .handover_o  (handover_o)
  );

  assign sda_pd_o = ext_sda_pd | int_sda_pd;
  assign scl_pd_o = ext_hold;

  AST_BAD_CFG_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad |-> !scl_pd_o); // R1
  AST_STRETCH_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pd_o |-> !ext_sda_pd); // R9
  AST_DEEP_INT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_sda_pd) |-> $past(awake)); // R2
endmodule

// File: tb/i2cw_front_bench.sv
`timescale 1ns/1ps
module i2cw_front_bench;
  localparam time CLK_HALF = 4ns;
  localparam time Q        = 200ns;
  localparam logic [6:0] SLAVE = 7'h5A;

  typedef struct packed {
    logic       am, op, bufd;
    logic [1:0] pwr;
    logic       nack, rdy, rw;
    logic [6:0] addr;
    logic       e_ack, e_str, e_wake;
    logic [1:0] e_hand;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  // pwr encoding: 0 Active, 1 Sleep, 2 Deep-Sleep
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,7'h5A, 1'b1,1'b0,1'b0,2'd1, 4'd2},  // R2 active
    '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,7'h5A, 1'b1,1'b0,1'b0,2'd1, 4'd2},  // R2 sleep, R5 no cause
    '{1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,7'h5A, 1'b0,1'b0,1'b0,2'd0, 4'd2},  // R2 deep silent
    '{1'b1,1'b0,1'b0,2'd2,1'b1,1'b0,1'b0,7'h5A, 1'b0,1'b0,1'b1,2'd0, 4'd8},  // R8 nack, R3 deep
    '{1'b1,1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,7'h5A, 1'b0,1'b1,1'b1,2'd1, 4'd9},  // R9 stretch
    '{1'b1,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,7'h5A, 1'b1,1'b0,1'b1,2'd1, 4'd7},  // R7 ready ack
    '{1'b1,1'b0,1'b0,2'd1,1'b0,1'b1,1'b1,7'h5A, 1'b1,1'b0,1'b1,2'd1, 4'd4},  // R4 rw ignored
    '{1'b1,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,7'h5B, 1'b0,1'b0,1'b0,2'd0, 4'd4},  // R4 lsb mismatch
    '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,7'h5A, 1'b0,1'b0,1'b0,2'd0, 4'd1},  // R1 am0 op1
    '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1,1'b0,7'h5A, 1'b0,1'b0,1'b0,2'd0, 4'd1},  // R1 unbuffered op1
    '{1'b1,1'b1,1'b1,2'd1,1'b0,1'b1,1'b0,7'h5A, 1'b1,1'b0,1'b1,2'd1, 4'd3},  // R3 buffered ext
    '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b1,7'h1A, 1'b0,1'b0,1'b0,2'd0, 4'd4},  // R4 msb mismatch
    '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b1,1'b1,7'h5A, 1'b1,1'b0,1'b0,2'd1, 4'd4}   // R4 rw ignored int
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic am = 1'b0, op = 1'b0, bufd = 1'b0, nack = 1'b0, rdy = 1'b0;
  logic [1:0] pwr = 2'd0;
  logic mask = 1'b0, clr = 1'b0;
  logic sda_pd, scl_pd, wake, irq, hand;
  wire  scl_line = scl_m & ~scl_pd;
  wire  sda_line = sda_m & ~sda_pd;
  int   checks = 0, errors = 0, hand_cnt = 0;
  bit   done = 1'b0;

  always #CLK_HALF clk = ~clk;
  always @(posedge clk) if (hand === 1'b1) hand_cnt <= hand_cnt + 1;

  i2cw_front u_i2cw_front (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .addr_ext_clk_i(am), .op_ext_clk_i(op), .buffered_i(bufd), .pwr_state_i(pwr),
    .nack_not_ready_i(nack), .core_ready_i(rdy), .slave_addr_i(SLAVE),
    .wake_mask_i(mask), .wake_clr_i(clr), .sda_pd_o(sda_pd), .scl_pd_o(scl_pd),
    .wake_cause_o(wake), .irq_o(irq), .handover_o(hand)
  );

  task automatic check(input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic sync_phase();
    @(negedge clk); #1;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack, output logic str);
    sda_m = 1'b0; #(Q); scl_m = 1'b0; #(Q);
    for (int i = 0; i < 8; i++) begin
      sda_m = (i < 7) ? a[6-i] : rw;
      #(Q); scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #(Q);
    end
    sda_m = 1'b1; #(Q); scl_m = 1'b1; #(Q);
    str = (scl_line == 1'b0);
    if (str) begin
      @(negedge clk); rdy = 1'b1;
      @(posedge clk); #1;
      check("R9 release one clock after ready", {3'b0, scl_pd}, 4'd0);
    end
    wait (scl_line === 1'b1);
    sync_phase();
    #(Q); ack = !sda_line; #(Q); scl_m = 1'b0; #(Q);
  endtask

  task automatic send_stop();
    sda_m = 1'b0; #(Q); scl_m = 1'b1; #(Q); sda_m = 1'b1; #(2*Q);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0; #1;
  endtask

  initial begin
    #(1600us);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, str;
    int   h0;
    #3;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check("R11 reset sda_pd", {3'b0, sda_pd}, 4'd0);
    check("R11 reset scl_pd", {3'b0, scl_pd}, 4'd0);
    check("R11 reset wake", {3'b0, wake}, 4'd0);
    check("R11 reset irq", {3'b0, irq}, 4'd0);
    check("R11 reset handover", {3'b0, hand}, 4'd0);
    #3 rst_n = 1'b1;
    #(Q);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      am = v.am; op = v.op; bufd = v.bufd; pwr = v.pwr; nack = v.nack; rdy = v.rdy;
      pulse_clear();
      h0 = hand_cnt;
      send_addr(v.addr, v.rw, ack, str);
      send_stop();
      repeat (10) @(negedge clk);
      #1;
      check($sformatf("R%0d vec%0d ack", v.req, i), {3'b0, ack}, {3'b0, v.e_ack});
      check($sformatf("R%0d vec%0d stretch", v.req, i), {3'b0, str}, {3'b0, v.e_str});
      check($sformatf("R%0d vec%0d wake (R5)", v.req, i), {3'b0, wake}, {3'b0, v.e_wake});
      check($sformatf("R%0d vec%0d handover count", v.req, i), 4'(hand_cnt - h0), {2'b0, v.e_hand});
    end

    // R10 repeated START mid-address
    am = 1'b1; op = 1'b0; bufd = 1'b0; pwr = 2'd0; nack = 1'b0; rdy = 1'b1;
    pulse_clear();
    sda_m = 1'b0; #(Q); scl_m = 1'b0; #(Q);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[1];
      #(Q); scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #(Q);
    end
    sda_m = 1'b1; #(Q); scl_m = 1'b1; #(Q);
    send_addr(SLAVE, 1'b0, ack, str);
    send_stop();
    repeat (10) @(negedge clk);
    #1;
    check("R10 ack after repeated start", {3'b0, ack}, 4'd1);
    check("R5 wake set by bus match", {3'b0, wake}, 4'd1);

    // R6 mask
    check("R6 irq masked", {3'b0, irq}, 4'd0);
    mask = 1'b1; #1;
    check("R6 irq unmasked", {3'b0, irq}, 4'd1);
    repeat (5) @(negedge clk);
    #1;
    check("R5 wake sticky", {3'b0, wake}, 4'd1);
    pulse_clear();
    check("R5 wake cleared", {3'b0, wake}, 4'd0);
    check("R6 irq follows clear", {3'b0, irq}, 4'd0);
    mask = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule